// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block watches over a processor and drives a single stretched reset line. Three events can start a reset: the supply coming up, the supply sagging while the system runs, and the processor failing to service its watchdog. An external comparator turns the supply voltage into a digital `supply_ok` flag. The processor services the watchdog by toggling `wdt_in`. The `wdt_en` flag takes the place of a floating watchdog pin: when it is low, the watchdog is switched off.

Time is counted in ticks. A prescaler divides the free-running clock by `TICK_DIV` to make them. The reset pulse width and the watchdog timeout are both parameters given in ticks. The defaults give a 1 ms tick at 125 MHz, a 200 ms pulse and a 1.6 s timeout. A build-time parameter sets whether the reset line is active-low or active-high. A two-bit cause output reports what started the most recent reset.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `supply_ok` is low, reset is asserted in the same cycle, with no clock edge needed.
- R2: After `supply_ok` rises, reset stays asserted for `PULSE_TICKS*TICK_DIV` clocks and then releases.
- R3: A fall of `supply_ok` while the system runs is a brown-out. Reset covers the whole low time plus one full pulse, and `cause` reads 2'b10.
- R4: With `wdt_en` high, if `wdt_in` keeps one level (high or low) for `TIMEOUT_TICKS` ticks, a reset pulse of `PULSE_TICKS*TICK_DIV` clocks follows and `cause` reads 2'b11.
- R5: Every rising or falling edge of `wdt_in` restarts the timeout interval. Toggling faster than the timeout never causes a reset.
- R6: If `wdt_in` never changes, watchdog resets repeat every `(TIMEOUT_TICKS+PULSE_TICKS)*TICK_DIV` clocks.
- R7: While `wdt_en` is low, the watchdog never causes a reset.
- R8: With `RST_ACTIVE_HIGH`=0, `rst_out` is low while reset is asserted. With `RST_ACTIVE_HIGH`=1, it is high while reset is asserted.
- R9: After the first power-up from a low supply, `cause` reads 2'b01. It keeps that value until a later brown-out or watchdog reset replaces it.
- R10: The watchdog count is held at zero during any reset. After a reset releases with `wdt_in` stuck, the next watchdog reset starts exactly `TIMEOUT_TICKS*TICK_DIV` clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| supply_ok | input | 1 | Supply-good flag from the external comparator, high when supply is good |
| wdt_in | input | 1 | Watchdog service input, toggled by the processor |
| wdt_en | input | 1 | Watchdog enable, low models a floating service pin |
| rst_out | output | 1 | Stretched reset, polarity set by `RST_ACTIVE_HIGH` |
| cause | output | 2 | Cause of the most recent reset: 01 power-up, 10 brown-out, 11 watchdog |

## Verification
The hardest case to reach is the exact start of the first watchdog interval after a brown-out, because an edge on `wdt_in` at any point restarts the count with a jitter of up to one tick. The bench leaves `wdt_in` untouched from before the supply drop. The only restart is then the release of the reset itself, which is aligned to the prescaler. The gap from release to the next reset is therefore an exact clock count. The reset train from a stuck input is measured between successive pulse starts, and its period is compared against the timeout plus the pulse width.

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int TICK_DIV        = 125000,
  parameter int PULSE_TICKS     = 200,
  parameter int TIMEOUT_TICKS   = 1600,
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       wdt_in,
  input  logic       wdt_en,
  output logic       rst_out,
  output logic [1:0] cause
);

  localparam int PW  = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
  localparam int PCW = $clog2(PULSE_TICKS + 1);
  localparam int WCW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [1:0] C_POWER = 2'b01;
  localparam logic [1:0] C_BROWN = 2'b10;
  localparam logic [1:0] C_WDOG  = 2'b11;

  logic [PW-1:0]  presc;
  logic [PCW-1:0] pcnt;
  logic [WCW-1:0] wcnt;
  logic [2:0]     wsync;
  logic           pulse_active;
  logic           supply_q;

  wire tick    = presc == PW'(TICK_DIV - 1);
  wire wd_edge = wsync[2] ^ wsync[1];
  wire wd_fire = tick && wdt_en && !pulse_active && supply_ok &&
                 wcnt == WCW'(TIMEOUT_TICKS - 1);
  wire rst_act = !supply_ok || pulse_active;

  assign rst_out = RST_ACTIVE_HIGH ? rst_act : !rst_act;

  always_ff @(posedge clk) begin
    wsync    <= {wsync[1:0], wdt_in};
    supply_q <= supply_ok;
  end

  // prescaler realigns at the start of every pulse so pulse widths are exact
  always_ff @(posedge clk) begin
    if (!supply_ok || wd_fire || tick) presc <= '0;
    else                               presc <= presc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!supply_ok || wd_fire) begin
      pulse_active <= 1'b1;
      pcnt         <= '0;
    end else if (pulse_active && tick) begin
      if (pcnt == PCW'(PULSE_TICKS - 1)) begin
        pulse_active <= 1'b0;
        pcnt         <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!supply_ok || pulse_active || !wdt_en || wd_edge || wd_fire) wcnt <= '0;
    else if (tick)                                                 wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      if (supply_q)              cause <= C_BROWN;
      else if (cause == C_BROWN) cause <= C_BROWN;
      else                       cause <= C_POWER;
    end else if (wd_fire) begin
      cause <= C_WDOG;
    end
  end

endmodule

module supv_reset_chk #(
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input logic       clk,
  input logic       supply_ok,
  input logic       wdt_en,
  input logic       rst_out,
  input logic [1:0] cause,
  input logic       pulse_active,
  input logic       wd_idle
);

  wire asserted = ACTIVE_HIGH ? rst_out : !rst_out;

  // R1
  always_ff @(posedge clk)
    if (!supply_ok) supply_low_rst_chk: assert (asserted);

  // R2
  supply_rise_hold_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(supply_ok) |-> asserted);

  // R4
  wdog_cause_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(pulse_active) |-> cause == 2'b11);

  // R7
  wdog_off_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    (!wdt_en && !pulse_active) |=> !pulse_active);

  // R10
  wdog_clear_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    pulse_active |=> wd_idle);

endmodule

bind supv_reset_ctrl supv_reset_chk #(.ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_chk (
  .clk(clk), .supply_ok(supply_ok), .wdt_en(wdt_en), .rst_out(rst_out),
  .cause(cause), .pulse_active(pulse_active), .wd_idle(wcnt == '0)
);

// File: tb/sim_supv_reset_ctrl.sv
`timescale 1ns/1ps
module sim_supv_reset_ctrl;
  localparam int DIV = 4, PT = 10, TT = 30;
  localparam int PLEN = PT * DIV;

  logic clk = 0, supply_ok, wdt_in, wdt_en;
  logic rst_lo, rst_hi;
  logic [1:0] cause, cause_hi;
  int cyc = 0, checks = 0, fails = 0, pulses = 0, len = 0;
  bit act_q = 0, done = 0;
  int starts[$], releases[$];

  typedef struct { logic [1:0] c; int lo; int hi; string req; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  supv_reset_ctrl #(.TICK_DIV(DIV), .PULSE_TICKS(PT), .TIMEOUT_TICKS(TT), .RST_ACTIVE_HIGH(0)) u0 (
    .clk(clk), .supply_ok(supply_ok), .wdt_in(wdt_in), .wdt_en(wdt_en), .rst_out(rst_lo), .cause(cause));
  supv_reset_ctrl #(.TICK_DIV(DIV), .PULSE_TICKS(PT), .TIMEOUT_TICKS(TT), .RST_ACTIVE_HIGH(1)) u1 (
    .clk(clk), .supply_ok(supply_ok), .wdt_in(wdt_in), .wdt_en(wdt_en), .rst_out(rst_hi), .cause(cause_hi));

  task automatic chk(bit ok, string req, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic push(logic [1:0] c, int lo, int hi, string req);
    exp_t e;
    e.c = c; e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic service(int n, int gap);
    for (int i = 0; i < n; i++) begin
      wdt_in = ~wdt_in;
      wait_clk(gap);
    end
  endtask

  // monitor: measures every reset pulse on the active-low instance
  always @(negedge clk) begin
    bit act;
    act = !rst_lo;
    if (act && !act_q) begin
      starts.push_back(cyc);
      len = 0;
    end
    if (act) len++;
    if (!act && act_q) begin
      exp_t e;
      pulses++;
      releases.push_back(cyc);
      if (q.size() == 0) begin
        chk(0, "R5/R7", "unexpected reset pulse length", len, 0);
      end else begin
        e = q.pop_front();
        chk(len >= e.lo && len <= e.hi, e.req, "pulse length", len, (e.lo + e.hi) / 2);
        chk(cause == e.c, e.req, "cause at release", cause, e.c);
      end
    end
    act_q = act;
  end

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", "run did not finish", cyc, 0);
    summary();
  end

  initial begin
    supply_ok = 0; wdt_in = 0; wdt_en = 1;
    @(negedge clk);
    chk(rst_lo == 0, "R1", "reset low at start", rst_lo, 0);
    chk(rst_hi == 1, "R8", "active-high copy", rst_hi, 1);
    push(2'b01, 20 + PLEN - 3, 20 + PLEN + 3, "R2");
    wait_clk(20);
    supply_ok = 1;
    wait_clk(20);
    chk(rst_lo == 0, "R2", "still held mid pulse", rst_lo, 0);
    chk(rst_hi == !rst_lo, "R8", "polarity mid pulse", rst_hi, !rst_lo);
    wait_clk(30);
    chk(rst_lo == 1, "R2", "released after pulse", rst_lo, 1);
    chk(cause == 2'b01, "R9", "power-up cause", cause, 1);

    service(12, 50);
    chk(pulses == 1, "R5", "no reset while serviced", pulses, 1);
    chk(cause == 2'b01, "R9", "cause kept", cause, 1);

    // stuck input: reset train
    push(2'b11, PLEN - 2, PLEN + 2, "R4");
    push(2'b11, PLEN - 2, PLEN + 2, "R6");
    push(2'b11, PLEN - 2, PLEN + 2, "R6");
    wait_clk(450);
    chk(pulses == 4, "R4", "watchdog pulses", pulses, 4);
    if (starts.size() >= 4) begin
      chk(starts[2] - starts[1] == (TT + PT) * DIV, "R6", "train period", starts[2] - starts[1], (TT + PT) * DIV);
      chk(starts[3] - starts[2] == (TT + PT) * DIV, "R6", "train period", starts[3] - starts[2], (TT + PT) * DIV);
    end
    service(4, 50);
    chk(rst_lo == 1 && rst_hi == 0, "R8", "both released", rst_hi, 0);

    // watchdog disabled with stuck input
    wdt_en = 0;
    wait_clk(600);
    chk(pulses == 4, "R7", "disabled watchdog quiet", pulses, 4);
    wdt_en = 1;
    service(4, 50);
    chk(pulses == 4, "R5", "re-enabled and serviced", pulses, 4);

    // brown-out, then stuck input
    supply_ok = 0;
    wait_clk(2);
    chk(rst_lo == 0, "R1", "reset during sag", rst_lo, 0);
    chk(cause == 2'b10, "R3", "brown-out cause", cause, 2);
    push(2'b10, 15 + PLEN - 3, 15 + PLEN + 3, "R3");
    push(2'b11, PLEN - 2, PLEN + 2, "R10");
    wait_clk(13);
    supply_ok = 1;
    wait_clk(PLEN + TT * DIV + PLEN + 20);
    chk(pulses == 6, "R10", "pulse count", pulses, 6);
    if (starts.size() >= 6 && releases.size() >= 5)
      chk(starts[5] - releases[4] == TT * DIV, "R10", "release to watchdog reset",
          starts[5] - releases[4], TT * DIV);
    service(2, 20);
    chk(q.size() == 0, "R4", "expected pulses left", q.size(), 0);
    summary();
  end
endmodule